// File: doc/BRIEF.md
# Power-Up Reset Release Sequencer

This block decides when a small microcontroller core may leave reset after power is applied. Once the power-on pulse ends, it runs a power-up timer that counts ticks of a free-running slow timer. In crystal oscillator modes it then runs an oscillator start-up timer that counts main-clock cycles. The core is let go only after both waits are over and the external master-clear pin is high.

Both waits run from the power-on pulse, whatever the state of the master-clear pin. If the pin is still held low when they finish, the core starts a fixed, short latency after the pin rises. Later master-clear or watchdog resets hold the core only while they are asserted and do not restart either timer.

When the core wakes from sleep in a crystal mode, the block applies the same oscillator start-up wait through a stall output. In the other modes no wait is applied. The analog power-on and brown-out detectors, the watchdog and the clock sources are outside the block and appear only as inputs.

Top module: `rst_release_seq`

## Requirements
- R1: While `pwr_on_n_i` is low, `core_rst_n_o` and `wake_stall_o` are low. Neither output rises before the internal reset has been released, which takes two synchronizer edges after `pwr_on_n_i` rises.
- R2: With `pwrt_dis_i`=0, the power-up timer starts at the third clock edge after `pwr_on_n_i` rises. It ends on the edge at which the PWRT_TICKS-th `slow_tick_i` pulse is sampled. In a non-crystal mode `core_rst_n_o` rises one edge after that.
- R3: With `pwrt_dis_i`=1, the power-up timer is bypassed and `slow_tick_i` has no effect. In a non-crystal mode `core_rst_n_o` rises on the fourth clock edge after `pwr_on_n_i` rises.
- R4: `osc_mode_i` codes 0, 1 and 2 (the three crystal modes) add an oscillator start-up wait of OST_CYCLES clock edges, which begins after the power-up timer ends. Release comes at edge L+OST_CYCLES+1, where L is the edge on which the power-up timer ends (L=3 when it is bypassed).
- R5: `osc_mode_i` codes 3 to 7 skip the oscillator start-up wait, so release comes at edge L+1.
- R6: The time-outs run while `mclr_n_i` is low. If the pin is still low after they end, `core_rst_n_o` stays low and then rises on the third clock edge after the pin goes high.
- R7: After release, a low level on `mclr_n_i` drops `core_rst_n_o` on the third edge after the pin falls. The output returns on the third edge after the pin rises, with no timer rerun.
- R8: `wdt_rst_i` high at an edge makes `core_rst_n_o` low after that edge. The output returns at the first edge at which `wdt_rst_i` is low, with no timer rerun.
- R9: In a crystal mode, a one-cycle `wake_i` pulse while the core is released raises `wake_stall_o` at the edge that samples it. The stall stays high for exactly OST_CYCLES cycles, and `core_rst_n_o` stays high throughout.
- R10: In a non-crystal mode (codes 3 to 7), `wake_i` never raises `wake_stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| pwr_on_n_i | input | 1 | Power-on reset pulse, active low, asynchronous |
| mclr_n_i | input | 1 | External master-clear pin, active low, asynchronous |
| osc_mode_i | input | 3 | Oscillator mode: 0..2 crystal types, 3..7 clock/RC/internal |
| pwrt_dis_i | input | 1 | 1 bypasses the power-up timer |
| slow_tick_i | input | 1 | One-cycle tick from the slow free-running timer |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous |
| wake_i | input | 1 | One-cycle wake-from-sleep request |
| core_rst_n_o | output | 1 | Registered core release, high = run |
| wake_stall_o | output | 1 | High while the wake start-up wait runs |

## Verification
The bench powers the block up in all eight oscillator codes, each with the power-up timer both enabled and bypassed, and predicts the release edge from the tick period and the counter lengths. These sixteen runs tell apart the four sequencing paths and show whether the crystal/non-crystal split falls on the right codes. Further runs hold master-clear low through power-up, pulse master-clear and the watchdog after release, and request a wake in a crystal mode and in a non-crystal mode. These separate the timer path from the pin path and confirm the exact length of the stall window.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam logic [2:0] OSC_LP  = 3'd0;
  localparam logic [2:0] OSC_XT  = 3'd1;
  localparam logic [2:0] OSC_HS  = 3'd2;
  localparam logic [2:0] OSC_EC  = 3'd3;
  localparam logic [2:0] OSC_RC  = 3'd4;
  localparam logic [2:0] OSC_INT = 3'd5;

  typedef enum logic [1:0] {
    ST_PWRT = 2'd0,
    ST_OST  = 2'd1,
    ST_RUN  = 2'd2,
    ST_WAKE = 2'd3
  } seq_state_e;

  function automatic logic is_xtal(input logic [2:0] mode);
    return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
  endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_n = d_i;
    end else begin : g_chain
      always_comb sh_n = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sh_q <= '0;
    else           sh_q <= sh_n;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/rst_seq_pwrt.sv
module rst_seq_pwrt #(
  parameter int TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = run_i && tick_i && at_last;

  always_comb begin
    cnt_n = cnt_q;
    if (!run_i)      cnt_n = '0;
    else if (tick_i) cnt_n = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_n;
  end

  // R2
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LAST);

  // R2
  tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rst_seq_cnt.sv
module rst_seq_cnt #(
  parameter int LEN = 1024
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic en_i,
  output logic last_o
);

  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  assign last_o = en_i && (cnt_q == LAST);

  always_comb begin
    if (en_i && !last_o) cnt_n = cnt_q + 1'b1;
    else                 cnt_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_n;
  end

  // R4
  ost_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LAST);

  // R9
  ost_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(en_i) |-> (cnt_q == '0));

endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS  = 4,
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       pwr_on_n_i,
  input  logic       mclr_n_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_dis_i,
  input  logic       slow_tick_i,
  input  logic       wdt_rst_i,
  input  logic       wake_i,
  output logic       core_rst_n_o,
  output logic       wake_stall_o
);

  logic       rst_n;
  logic       mclr_s;
  logic       xtal;
  logic       pwrt_run;
  logic       pwrt_exp;
  logic       ost_en;
  logic       ost_last;
  seq_state_e st_q, st_n;
  logic       rel_q, rel_n;
  logic       stall_q, stall_n;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (pwr_on_n_i),
    .d_i      (1'b1),
    .q_o      (rst_n)
  );

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
    .clk_i    (clk_i),
    .arst_n_i (pwr_on_n_i),
    .d_i      (mclr_n_i),
    .q_o      (mclr_s)
  );

  assign xtal     = is_xtal(osc_mode_i);
  assign pwrt_run = (st_q == ST_PWRT) && !pwrt_dis_i;
  assign ost_en   = (st_q == ST_OST) || (st_q == ST_WAKE);

  rst_seq_pwrt #(.TICKS(PWRT_TICKS)) u_pwrt (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .run_i    (pwrt_run),
    .tick_i   (slow_tick_i),
    .expire_o (pwrt_exp)
  );

  rst_seq_cnt #(.LEN(OST_CYCLES)) u_ost (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .en_i    (ost_en),
    .last_o  (ost_last)
  );

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_PWRT: if (pwrt_dis_i || pwrt_exp) st_n = xtal ? ST_OST : ST_RUN;
      ST_OST:  if (ost_last)               st_n = ST_RUN;
      ST_RUN:  if (wake_i && xtal)         st_n = ST_WAKE;
      ST_WAKE: if (ost_last)               st_n = ST_RUN;
      default:                             st_n = ST_PWRT;
    endcase
  end

  always_comb begin
    rel_n   = ((st_q == ST_RUN) || (st_q == ST_WAKE)) && mclr_s && !wdt_rst_i;
    stall_n = (st_n == ST_WAKE);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PWRT;
      rel_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      rel_q   <= rel_n;
      stall_q <= stall_n;
    end
  end

  assign core_rst_n_o = rel_q;
  assign wake_stall_o = stall_q;

  // R1
  rel_after_timeouts_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    core_rst_n_o |-> (st_q == ST_RUN || st_q == ST_WAKE));

  // R2
  pwrt_wait_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_PWRT && !pwrt_dis_i && !slow_tick_i) |=> (st_q == ST_PWRT));

  // R5
  no_ost_soft_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_PWRT && !xtal) |=> (st_q != ST_OST));

  // R7
  mclr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mclr_s |=> !core_rst_n_o);

  // R8
  wdt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wdt_rst_i |=> !core_rst_n_o);

  // R9
  stall_in_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_stall_o |-> (st_q == ST_WAKE));

  // R10
  no_soft_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_RUN && !xtal) |=> !wake_stall_o);

endmodule

// File: tb/rst_release_seq_test.sv
`timescale 1ns/1ps
module rst_release_seq_test;

  localparam int P  = 4;
  localparam int T  = 5;
  localparam int N  = 1024;
  localparam int WD = 200000;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       mclr_n;
  logic [2:0] mode;
  logic       pdis;
  logic       tick;
  logic       wdt;
  logic       wake;
  logic       rel;
  logic       stall;

  int checks   = 0;
  int failures = 0;
  int ecnt     = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  rst_release_seq #(.PWRT_TICKS(P), .OST_CYCLES(N), .SYNC_STAGES(2)) uut (
    .clk_i        (clk),
    .pwr_on_n_i   (arst_n),
    .mclr_n_i     (mclr_n),
    .osc_mode_i   (mode),
    .pwrt_dis_i   (pdis),
    .slow_tick_i  (tick),
    .wdt_rst_i    (wdt),
    .wake_i       (wake),
    .core_rst_n_o (rel),
    .wake_stall_o (stall)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!arst_n) ecnt <= 0;
    else         ecnt <= ecnt + 1;
  end

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = arst_n && (((ecnt + 1) % T) == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic int rel_edge(input int m, input bit off);
    int l = off ? 3 : P * T;
    bit x = (m <= 2);
    return l + (x ? N : 0) + 1;
  endfunction

  task automatic power_on(input logic [2:0] m, input bit off, input bit pin);
    @(negedge clk);
    arst_n = 1'b0;
    mode   = m;
    pdis   = off;
    mclr_n = pin;
    repeat (3) @(negedge clk);
    chk(rel == 1'b0, "R1 release in reset", rel, 0);
    chk(stall == 1'b0, "R1 stall in reset", stall, 0);
    arst_n = 1'b1;
  endtask

  task automatic sweep_run(input logic [2:0] m, input bit off);
    int  r = rel_edge(m, off);
    bit  early = 1'b0;
    string tag_t = off ? "R3" : "R2";
    string tag_o = (m <= 2) ? "R4" : "R5";
    power_on(m, off, 1'b1);
    forever begin
      @(negedge clk);
      if (ecnt < r) begin
        if (rel) early = 1'b1;
      end else begin
        chk(!early, $sformatf("%s/%s early release mode=%0d", tag_t, tag_o, m), early, 0);
        chk(rel == 1'b1, $sformatf("%s/%s release at edge %0d mode=%0d", tag_t, tag_o, r, m), rel, 1);
        break;
      end
    end
  endtask

  initial begin
    arst_n = 1'b0; mclr_n = 1'b1; mode = 3'd0; pdis = 1'b0;
    wdt = 1'b0; wake = 1'b0;

    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 2; d++)
        sweep_run(3'(m), d[0]);

    // R6: master-clear held low through both time-outs (XT, timer on)
    begin
      int r = rel_edge(1, 1'b0);
      bit early = 1'b0;
      power_on(3'd1, 1'b0, 1'b0);
      while (ecnt < r + 40) begin
        @(negedge clk);
        if (rel) early = 1'b1;
      end
      chk(!early, "R6 held by pin", early, 0);
      mclr_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(rel == 1'b0, "R6 second edge after rise", rel, 0);
      @(negedge clk);
      chk(rel == 1'b1, "R6 third edge after rise", rel, 1);
    end

    // R7: master-clear pulse in normal operation
    repeat (5) @(negedge clk);
    mclr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rel == 1'b1, "R7 second edge after fall", rel, 1);
    @(negedge clk);
    chk(rel == 1'b0, "R7 third edge after fall", rel, 0);
    repeat (10) @(negedge clk);
    mclr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rel == 1'b0, "R7 second edge after rise", rel, 0);
    @(negedge clk);
    chk(rel == 1'b1, "R7 third edge after rise, no rerun", rel, 1);

    // R8: watchdog pulse
    repeat (3) @(negedge clk);
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
    chk(rel == 1'b0, "R8 dropped after wdt edge", rel, 0);
    @(negedge clk);
    chk(rel == 1'b1, "R8 back next edge", rel, 1);

    // R9: wake in crystal mode
    repeat (3) @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk(stall == 1'b1, "R9 stall at wake edge", stall, 1);
    begin
      bit drop = 1'b0;
      bit lost = 1'b0;
      for (int j = 1; j <= N; j++) begin
        @(negedge clk);
        if (j < N && !stall) drop = 1'b1;
        if (!rel) lost = 1'b1;
        if (j == N) chk(stall == 1'b0, "R9 stall ends after OST_CYCLES", stall, 0);
      end
      chk(!drop, "R9 stall held full window", drop, 0);
      chk(!lost, "R9 release held during wake", lost, 0);
    end

    // R10: wake in non-crystal mode
    sweep_run(3'd3, 1'b1);
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    begin
      bit seen = 1'b0;
      for (int j = 0; j < 40; j++) begin
        if (stall) seen = 1'b1;
        @(negedge clk);
      end
      chk(!seen, "R10 no stall in EC mode", seen, 0);
      chk(rel == 1'b1, "R10 release kept", rel, 1);
    end

    summary();
  end

  initial begin
    wait (cycles >= WD);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WD);
    summary();
  end

endmodule